// File: doc/BRIEF.md
# PCM Frame Sequencer

This block sits on the master side of a PCM telemetry encoder. It walks an external format memory of 24-bit entries, one entry for each PCM word of the frame. An entry either holds a fixed word, such as a sync pattern or the mission-mode identifier, or holds a request word for a remote data-collection module. For a request entry the block sends the request on the request bus and collects the 8-bit reply. It then serializes every PCM word MSB first, one bit per clock. Output runs one word slot behind the fetch, so a reply always lands in the slot that follows its request.

A jumper input splits the format memory into 1, 2, 4 or 8 equal regions, and each region holds one independent format. The mission-mode input picks the region. The block samples the mode only when a frame ends, so a frame never mixes two formats. The memory is a plain synchronous-read array outside the block. The block drives the address and a read strobe, and the data is expected one clock later. Reset assertion is asynchronous. Its release must be synchronous to `clk`.

Top module: `pcm_frame_sequencer`

## Requirements
- R1: While reset is held, `pcm_bit`, `word_sync`, `frame_sync` and `req_valid` are 0. After reset the active mode is 0, and the first fetch reads address 0.
- R2: A word slot lasts 16 clocks. `fmt_rd` is high for exactly one clock at the start of each slot. Inside a frame, each fetch address is the previous one plus 1.
- R3: An entry with bit 23 set and bit 21 clear is a literal. Its bits 15:0 are serialized MSB first during the slot after the one that fetched it. `word_sync` marks the first bit.
- R4: An entry with bit 23 clear is a request. `req_valid` pulses for one clock, two clocks after its fetch strobe, with `req_word` equal to entry bits 15:0. A literal entry raises no request.
- R5: A request entry produces the PCM word {entry bits 15:8, reply byte}. The reply byte is the last `rsp_data` seen with `rsp_valid` from the request pulse up to the end of that slot.
- R6: If a request gets no reply within its slot, the low byte of its word is {3'b000, entry bits 20:16}.
- R7: `rsp_valid` has no effect outside the reply window of a request slot. Literal words and replies are unchanged by it.
- R8: An entry with bit 22 set ends the frame, and the next fetch reads the base of the region. `frame_sync` is high together with `word_sync` on the first word of every frame.
- R9: `jumper_cfg` = j gives 2^j regions. The region base is (mode AND (2^j - 1)) shifted left by 15 - j.
- R10: A change of `mode_sel` takes effect only after the slot of an entry that ends the frame.
- R11: An entry with bits 23 and 21 both set outputs the mode word {13'h0F35, active mode}.
- R12: Without a frame end, the fetch offset wraps from the top of the region back to its base.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert, synchronous release |
| jumper_cfg | input | 2 | Region split: 2^value format regions |
| mode_sel | input | 3 | Mission-mode selection of the format region |
| fmt_addr | output | 15 | Format memory address |
| fmt_rd | output | 1 | Format memory read strobe, data due next clock |
| fmt_rdata | input | 24 | Format memory read data |
| req_valid | output | 1 | One-clock request strobe |
| req_word | output | 16 | Request word for the remote modules |
| rsp_valid | input | 1 | Reply byte strobe from a remote module |
| rsp_data | input | 8 | Reply byte |
| pcm_bit | output | 1 | Serial PCM output, MSB first |
| word_sync | output | 1 | High on the first bit of each PCM word |
| frame_sync | output | 1 | High on the first bit of each frame |

## Verification
The hardest state to reach from the ports is the offset wrap inside a region when no entry marks a frame end. It takes more than four thousand word slots. The bench gets there by pointing the mode at a region whose entries never set bit 22. It then counts fetches until the address returns from the region's top to its base. The other hard case is a stray reply that sits just outside a request's reply window. For this, the remote model drives `rsp_valid` on every clock except between a request pulse and the next fetch strobe. The stray bytes therefore fall on both edges of the window.

// File: rtl/pcm_seq_pkg.sv
package pcm_seq_pkg;
  localparam int WORD_W = 16;
  localparam int ENT_W  = 24;
  localparam int RSP_W  = 8;
  localparam int CNT_W  = $clog2(WORD_W);

  // format entry layout: bits 23/22/21 are decoded flags
  typedef struct packed {
    logic              lit;       // literal word
    logic              last;      // frame ends after this word
    logic              mode_ins;  // insert mission-mode word
    logic [4:0]        fill;      // low bits substituted on a missing reply
    logic [WORD_W-1:0] body;      // literal word or request word
  } fmt_ent_t;
endpackage

// File: rtl/pcm_seq_timer.sv
module pcm_seq_timer
  import pcm_seq_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  output logic slot_first,
  output logic ent_cap,
  output logic slot_last
);
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign slot_first = (cnt_q == '0);
  assign ent_cap    = (cnt_q == CNT_W'(1));
  assign slot_last  = (cnt_q == CNT_W'(WORD_W - 1));

  // R2
  slot_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    slot_last |=> slot_first);
endmodule

// File: rtl/pcm_seq_addr.sv
module pcm_seq_addr #(
  parameter int AW     = 15,
  parameter int MODE_W = 3,
  parameter int JMP_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              slot_last,
  input  logic              ent_last,
  input  logic [JMP_W-1:0]  jumper_cfg,
  input  logic [MODE_W-1:0] mode_sel,
  output logic [AW-1:0]     fmt_addr,
  output logic [MODE_W-1:0] act_mode,
  output logic              at_start
);
  localparam int SH_W = $clog2(AW + 1);

  logic [AW-1:0]     off_q, off_d;
  logic [MODE_W-1:0] mode_q, mode_d;
  logic              start_q, start_d;
  logic [JMP_W-1:0]  nb;
  logic [SH_W-1:0]   sh;
  logic [MODE_W-1:0] reg_mask;
  logic [AW-1:0]     off_mask, base;

  // region geometry from the jumper setting
  always_comb begin
    if (int'(jumper_cfg) > MODE_W) nb = JMP_W'(MODE_W);
    else                           nb = jumper_cfg;
    sh       = SH_W'(AW) - SH_W'(nb);
    reg_mask = ~({MODE_W{1'b1}} << nb);
    off_mask = {AW{1'b1}} >> nb;
    base     = AW'(mode_q & reg_mask) << sh;
  end

  // next state: advance only at slot end
  always_comb begin
    off_d   = off_q;
    mode_d  = mode_q;
    start_d = start_q;
    if (slot_last) begin
      start_d = ent_last;
      if (ent_last) begin
        off_d  = '0;
        mode_d = mode_sel;
      end else begin
        off_d  = (off_q + AW'(1)) & off_mask;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      off_q   <= '0;
      mode_q  <= '0;
      start_q <= 1'b1;
    end else begin
      off_q   <= off_d;
      mode_q  <= mode_d;
      start_q <= start_d;
    end
  end

  assign fmt_addr = base | (off_q & off_mask);
  assign act_mode = mode_q;
  assign at_start = start_q;

  // R10
  mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(slot_last && ent_last) |=> $stable(act_mode));
  // R8
  frame_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_last && ent_last) |=> at_start);
endmodule

// File: rtl/pcm_seq_word.sv
module pcm_seq_word
  import pcm_seq_pkg::*;
#(
  parameter int                           MODE_W      = 3,
  parameter logic [WORD_W-MODE_W-1:0]     MODE_PREFIX = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              slot_first,
  input  logic              ent_cap,
  input  logic              slot_last,
  input  logic [ENT_W-1:0]  fmt_rdata,
  input  logic              rsp_valid,
  input  logic [RSP_W-1:0]  rsp_data,
  input  logic [MODE_W-1:0] act_mode,
  input  logic              at_start,
  output logic              ent_last,
  output logic              req_valid,
  output logic [WORD_W-1:0] req_word,
  output logic              pcm_bit,
  output logic              word_sync,
  output logic              frame_sync
);
  fmt_ent_t          ent_q, ent_d, ent_in;
  logic              first_q, first_d;
  logic              req_q, req_d;
  logic              win_q, win_d;
  logic              got_q, got_d;
  logic [RSP_W-1:0]  hold_q, hold_d;
  logic [WORD_W-1:0] sh_q, sh_d;
  logic              sfirst_q, sfirst_d;
  logic              live_q, live_d;
  logic [RSP_W-1:0]  rsp_byte;
  logic [WORD_W-1:0] word;

  assign ent_in = fmt_ent_t'(fmt_rdata);

  // word assembly for the slot that is ending
  always_comb begin
    if (win_q && rsp_valid) rsp_byte = rsp_data;
    else if (got_q)         rsp_byte = hold_q;
    else                    rsp_byte = RSP_W'(ent_q.fill);
    if (ent_q.lit) begin
      if (ent_q.mode_ins) word = {MODE_PREFIX, act_mode};
      else                word = ent_q.body;
    end else begin
      word = {ent_q.body[WORD_W-1:RSP_W], rsp_byte};
    end
  end

  always_comb begin
    ent_d    = ent_cap ? ent_in : ent_q;
    first_d  = ent_cap ? at_start : first_q;
    req_d    = ent_cap && !ent_in.lit;
    win_d    = win_q;
    got_d    = got_q;
    hold_d   = hold_q;
    if (slot_last) begin
      win_d  = 1'b0;
      got_d  = 1'b0;
      hold_d = '0;
    end else begin
      if (ent_cap) win_d = !ent_in.lit;
      if (win_q && rsp_valid) begin
        got_d  = 1'b1;
        hold_d = rsp_data;
      end
    end
    sh_d     = slot_last ? word : {sh_q[WORD_W-2:0], 1'b0};
    sfirst_d = slot_last ? first_q : sfirst_q;
    live_d   = slot_last ? 1'b1 : live_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ent_q    <= '0;
      first_q  <= 1'b0;
      req_q    <= 1'b0;
      win_q    <= 1'b0;
      got_q    <= 1'b0;
      hold_q   <= '0;
      sh_q     <= '0;
      sfirst_q <= 1'b0;
      live_q   <= 1'b0;
    end else begin
      ent_q    <= ent_d;
      first_q  <= first_d;
      req_q    <= req_d;
      win_q    <= win_d;
      got_q    <= got_d;
      hold_q   <= hold_d;
      sh_q     <= sh_d;
      sfirst_q <= sfirst_d;
      live_q   <= live_d;
    end
  end

  assign ent_last   = ent_q.last;
  assign req_valid  = req_q;
  assign req_word   = ent_q.body;
  assign pcm_bit    = live_q & sh_q[WORD_W-1];
  assign word_sync  = live_q & slot_first;
  assign frame_sync = word_sync & sfirst_q;

  // R4
  req_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> !req_valid);
  // R4
  req_after_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> $past(ent_cap));
  // R8
  frame_in_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_sync |-> word_sync);
endmodule

// File: rtl/pcm_frame_sequencer.sv
module pcm_frame_sequencer
  import pcm_seq_pkg::*;
#(
  parameter int                       AW          = 15,
  parameter int                       MODE_W      = 3,
  parameter logic [WORD_W-MODE_W-1:0] MODE_PREFIX = 13'h0F35
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        jumper_cfg,
  input  logic [MODE_W-1:0] mode_sel,
  output logic [AW-1:0]     fmt_addr,
  output logic              fmt_rd,
  input  logic [ENT_W-1:0]  fmt_rdata,
  output logic              req_valid,
  output logic [WORD_W-1:0] req_word,
  input  logic              rsp_valid,
  input  logic [RSP_W-1:0]  rsp_data,
  output logic              pcm_bit,
  output logic              word_sync,
  output logic              frame_sync
);
  localparam int JMP_W = $clog2(MODE_W + 1);

  logic              slot_first, ent_cap, slot_last;
  logic              ent_last, at_start;
  logic [MODE_W-1:0] act_mode;

  pcm_seq_timer i_timer (
    .clk        (clk),
    .rst_n      (rst_n),
    .slot_first (slot_first),
    .ent_cap    (ent_cap),
    .slot_last  (slot_last)
  );

  pcm_seq_addr #(.AW(AW), .MODE_W(MODE_W), .JMP_W(JMP_W)) i_addr (
    .clk        (clk),
    .rst_n      (rst_n),
    .slot_last  (slot_last),
    .ent_last   (ent_last),
    .jumper_cfg (JMP_W'(jumper_cfg)),
    .mode_sel   (mode_sel),
    .fmt_addr   (fmt_addr),
    .act_mode   (act_mode),
    .at_start   (at_start)
  );

  pcm_seq_word #(.MODE_W(MODE_W), .MODE_PREFIX(MODE_PREFIX)) i_word (
    .clk        (clk),
    .rst_n      (rst_n),
    .slot_first (slot_first),
    .ent_cap    (ent_cap),
    .slot_last  (slot_last),
    .fmt_rdata  (fmt_rdata),
    .rsp_valid  (rsp_valid),
    .rsp_data   (rsp_data),
    .act_mode   (act_mode),
    .at_start   (at_start),
    .ent_last   (ent_last),
    .req_valid  (req_valid),
    .req_word   (req_word),
    .pcm_bit    (pcm_bit),
    .word_sync  (word_sync),
    .frame_sync (frame_sync)
  );

  assign fmt_rd = slot_first;

  // R2
  fetch_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fmt_rd |=> !fmt_rd);
endmodule

// File: tb/test_pcm_frame_sequencer.sv
module test_pcm_frame_sequencer;
  localparam time CLK_PERIOD = 10ns;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [1:0]  jumper_cfg;
  logic [2:0]  mode_sel;
  logic [14:0] fmt_addr;
  logic        fmt_rd;
  logic [23:0] fmt_rdata;
  logic        req_valid;
  logic [15:0] req_word;
  logic        rsp_valid;
  logic [7:0]  rsp_data;
  logic        pcm_bit, word_sync, frame_sync;

  int nchk = 0, nfail = 0;

  pcm_frame_sequencer i_pcm_frame_sequencer (
    .clk(clk), .rst_n(rst_n), .jumper_cfg(jumper_cfg), .mode_sel(mode_sel),
    .fmt_addr(fmt_addr), .fmt_rd(fmt_rd), .fmt_rdata(fmt_rdata),
    .req_valid(req_valid), .req_word(req_word),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .pcm_bit(pcm_bit), .word_sync(word_sync), .frame_sync(frame_sync)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // format memory contents, computed per address
  function automatic logic [23:0] ent_at(input logic [14:0] a);
    logic [11:0] o;
    o = a[11:0];
    case (a[14:12])
      3'd0: case (o)
              12'd0:   return 24'h80FAF3;
              12'd1:   return 24'h001234;
              12'd2:   return 24'h1321EE;
              12'd3:   return 24'hC00F0F;
              default: return 24'h80DEAD;
            endcase
      3'd2: return (o == 0) ? 24'h80AAAA : (o == 1) ? 24'h403377 : 24'h80DEAD;
      3'd4: return 24'hC04444;
      3'd5: return (o == 0) ? 24'hA00000 : (o == 1) ? 24'hC05555 : 24'h80DEAD;
      3'd6: return 24'hC06666;
      default: return {12'h800, o};
    endcase
  endfunction

  always @(posedge clk) if (fmt_rd) fmt_rdata <= ent_at(fmt_addr);

  // remote module model
  bit stray_en = 0;
  int pend = 0;
  bit quiet = 0;
  logic [7:0] pdat;
  always @(negedge clk) begin
    if (!rst_n) begin
      rsp_valid = 0; rsp_data = 0; pend = 0; quiet = 0;
    end else begin
      rsp_valid = 0; rsp_data = 0;
      if (fmt_rd) quiet = 0;
      if (req_valid) begin
        quiet = 1;
        if (req_word[7:0] != 8'hEE) begin pend = 6; pdat = req_word[7:0] ^ 8'h5A; end
      end else if (pend > 0) begin
        pend--;
        if (pend == 0) begin rsp_valid = 1; rsp_data = pdat; end
      end
      if (stray_en && !quiet && pend == 0 && !rsp_valid) begin
        rsp_valid = 1; rsp_data = 8'hC3;
      end
    end
  end

  // output and bus monitor
  logic [14:0] fa [64];
  int          fc [64];
  logic [15:0] words [64];
  bit          wfs [64];
  logic [15:0] rw [64];
  int          rdl [64];
  int nfetch, nword, nreq, cyc, last_fc, bpos;
  logic [14:0] prev_a, last_a;
  logic [15:0] cw;
  bit cfs;
  always @(negedge clk) begin
    if (!rst_n) begin
      nfetch = 0; nword = 0; nreq = 0; cyc = 0; bpos = 0; last_fc = 0;
    end else begin
      cyc++;
      if (fmt_rd) begin
        if (nfetch < 64) begin fa[nfetch] = fmt_addr; fc[nfetch] = cyc; end
        prev_a = last_a; last_a = fmt_addr; last_fc = cyc; nfetch++;
      end
      if (req_valid) begin
        if (nreq < 64) begin rw[nreq] = req_word; rdl[nreq] = cyc - last_fc; end
        nreq++;
      end
      if (word_sync) begin cw = {15'd0, pcm_bit}; cfs = frame_sync; bpos = 1; end
      else if (bpos > 0) begin cw = {cw[14:0], pcm_bit}; bpos++; end
      if (bpos == 16) begin
        if (nword < 64) begin words[nword] = cw; wfs[nword] = cfs; end
        nword++; bpos = 0;
      end
    end
  end

  task automatic chk_eq(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic do_reset(input logic [1:0] j, input logic [2:0] m);
    rst_n = 0; jumper_cfg = j; mode_sel = m;
    repeat (3) @(negedge clk);
    chk_eq("R1 outputs in reset", {28'd0, pcm_bit, word_sync, frame_sync, req_valid}, 32'd0);
    @(posedge clk); #1 rst_n = 1;
  endtask

  task automatic wait_fetch(input int n);
    while (nfetch < n) @(negedge clk);
  endtask

  task automatic wait_word(input int n);
    while (nword < n) @(negedge clk);
  endtask

  task automatic t_reset;
    do_reset(2'd3, 3'd3);
    wait_fetch(1);
    chk_eq("R1 first fetch address", 32'(fa[0]), 32'h0);
  endtask

  task automatic t_main;
    do_reset(2'd3, 3'd5);
    wait_fetch(8);
    wait_word(7);
    chk_eq("R2 slot length", 32'(fc[1] - fc[0]), 32'd16);
    chk_eq("R2 address step", 32'(fa[2]), 32'h2);
    chk_eq("R8 frame end to region base", 32'(fa[4]), 32'h5000);
    chk_eq("R8 frame restart", 32'(fa[6]), 32'h5000);
    chk_eq("R3 literal word", 32'(words[0]), 32'hFAF3);
    chk_eq("R3 literal last word", 32'(words[3]), 32'h0F0F);
    chk_eq("R5 reply merged", 32'(words[1]), 32'h126E);
    chk_eq("R6 missing reply fill", 32'(words[2]), 32'h2113);
    chk_eq("R11 mode word", 32'(words[4]), 32'h79AD);
    chk_eq("R8 frame_sync pattern", {25'd0, wfs[0], wfs[1], wfs[2], wfs[3], wfs[4], wfs[5], wfs[6]},
           32'b1000101);
    chk_eq("R4 request count", 32'(nreq), 32'd2);
    chk_eq("R4 request word", 32'(rw[0]), 32'h1234);
    chk_eq("R4 request delay", 32'(rdl[0]), 32'd2);
    chk_eq("R4 second request word", 32'(rw[1]), 32'h21EE);
  endtask

  task automatic t_modechg;
    do_reset(2'd3, 3'd0);
    wait_fetch(2);
    mode_sel = 3'd2;
    wait_fetch(7);
    chk_eq("R10 mode held mid-frame", 32'(fa[3]), 32'h3);
    chk_eq("R10 mode applied at boundary", 32'(fa[4]), 32'h2000);
    chk_eq("R10 new frame continues", 32'(fa[5]), 32'h2001);
  endtask

  task automatic t_stray;
    stray_en = 1;
    do_reset(2'd3, 3'd2);
    wait_word(7);
    chk_eq("R7 literal unaffected by stray", 32'(words[4]), 32'hAAAA);
    chk_eq("R7 reply unaffected by stray", 32'(words[5]), 32'h332D);
    chk_eq("R7 first literal unaffected", 32'(words[0]), 32'hFAF3);
    stray_en = 0;
  endtask

  task automatic t_jumper;
    do_reset(2'd1, 3'd5);
    wait_fetch(5);
    chk_eq("R9 two regions base", 32'(fa[4]), 32'h4000);
    do_reset(2'd2, 3'd7);
    wait_fetch(5);
    chk_eq("R9 four regions base", 32'(fa[4]), 32'h6000);
    do_reset(2'd0, 3'd7);
    wait_fetch(6);
    chk_eq("R9 single region base", 32'(fa[4]), 32'h0);
    chk_eq("R9 single region next", 32'(fa[5]), 32'h1);
  endtask

  task automatic t_wrap;
    do_reset(2'd3, 3'd7);
    wait_fetch(4 + 4097);
    chk_eq("R12 region top reached", 32'(prev_a), 32'h7FFF);
    chk_eq("R12 offset wraps to base", 32'(last_a), 32'h7000);
  endtask

  initial begin
    #(CLK_PERIOD * 190000);
    nfail++;
    $display("FAIL watchdog all-reqs actual=timeout expected=done");
    $display("  TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end

  initial begin
    rst_n = 0; jumper_cfg = 0; mode_sel = 0;
    t_reset();
    t_main();
    t_modechg();
    t_stray();
    t_jumper();
    t_wrap();
    $display("  TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end
endmodule